// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This block takes the already extracted opcode bytes of the instruction at a branch source, plus a few side flags, and reports what kind of control-flow change it was. The report is an 18-bit mask. One bit names the class of the event, and one bit tells whether the target runs at user or kernel privilege. A sampling or filtering unit compares this mask against a user-selected set of wanted branch kinds, and drops records whose mask is not a subset of that set.

Besides a plain opcode lookup, the block applies a few fixed rules. A record with a zero source or target address carries no type. An aborted record is reported as an abort. A jump from user code into the kernel that was not caused by a system-call or software-interrupt instruction is reported as a hardware interrupt or fault. A relative call with a zero displacement is kept apart from ordinary calls.

The block has one register stage. A result is presented one cycle after `in_valid_i`, together with `out_valid_o`, and it holds until the next valid input.

Top module: `br_type_classifier`

## Requirements
- R1: While `rst_ni` is low and after its release, `out_valid_o` is 0 and `type_o` is all zeros until the first valid input.
- R2: When `in_valid_i` is high at a clock edge, the result appears on `type_o` and `out_valid_o` is 1 after that edge. When `in_valid_i` is low, `out_valid_o` is 0 after the edge and `type_o` keeps its previous value, whatever the other inputs do.
- R3: If `src_zero_i` or `dst_zero_i` is set, the result is all zeros, regardless of every other input.
- R4: Otherwise, if `abort_i` is set, the result is the abort bit (bit 12) ORed with the target privilege bit.
- R5: Otherwise, if `op_ok_i` is 0, the result is the abort bit (bit 12) alone, with no privilege bit and no interrupt remap.
- R6: When `op0_i` is 0x0F, `op1_i` selects the class. 0x05 and 0x34 select system call (bit 4). 0x07 and 0x35 select system return (bit 5). 0x80..0x8F select conditional (bit 8). Every other value selects no type.
- R7: The one-byte opcodes 0x70..0x7F and 0xE0..0xE3 select conditional (bit 8). 0xC2, 0xC3, 0xCA and 0xCB select return (bit 3). 0xCF selects interrupt return (bit 7). 0xCC..0xCE select software interrupt (bit 6).
- R8: 0xE8 selects zero-length call (bit 15) when `imm_zero_i` is 1, and call (bit 2) otherwise. 0x9A selects call (bit 2). 0xE9..0xEB select jump (bit 9).
- R9: For 0xFF, a `modrm_reg_i` of 2 or 3 selects indirect call (bit 11), 4 or 5 selects indirect jump (bit 17), and any other value selects no type. Any opcode not listed in R6..R9 selects no type.
- R10: When `src_kern_i`=0 and `dst_kern_i`=1, the decoded class is replaced by hardware interrupt/fault (bit 10). This also applies when no type was decoded. It does not apply when the class is system call or software interrupt.
- R11: A non-zero decoded result is ORed with bit 1 when `dst_kern_i`=1, or with bit 0 when it is 0. A result with no type stays all zeros. At most one class bit (bits 17..2) and at most one privilege bit are ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Inputs below are valid this cycle |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte (used after 0x0F) |
| imm_zero_i | input | 1 | Relative call displacement is zero |
| modrm_reg_i | input | 3 | Reg field of the ModRM byte |
| op_ok_i | input | 1 | Opcode bytes could be fetched |
| abort_i | input | 1 | Record marks a transaction abort |
| src_zero_i | input | 1 | Source address is zero |
| dst_zero_i | input | 1 | Target address is zero |
| src_kern_i | input | 1 | Source is kernel (1) or user (0) |
| dst_kern_i | input | 1 | Target is kernel (1) or user (0) |
| out_valid_o | output | 1 | Result valid this cycle |
| type_o | output | 18 | Branch type mask |

## Verification
Every result is due exactly one clock edge after the edge at which `in_valid_i` is sampled high. No other register lies on the path. The bench drives inputs on the falling edge and raises `in_valid_i` for one cycle. It then samples `out_valid_o` and `type_o` on the next falling edge, which is half a cycle after the capturing edge. The hold behaviour is checked one and two cycles later, after the bench has changed the data inputs while `in_valid_i` is low. Two back-to-back valid inputs are also checked, to show that each result lands in its own cycle.

// File: rtl/br_cls_pkg.sv
package br_cls_pkg;
  localparam int TYPE_W = 18;
  localparam int OP_W   = 8;
  localparam int REG_W  = 3;

  localparam int B_USER    = 0;
  localparam int B_KERN    = 1;
  localparam int B_CALL    = 2;
  localparam int B_RET     = 3;
  localparam int B_SYSCALL = 4;
  localparam int B_SYSRET  = 5;
  localparam int B_INT     = 6;
  localparam int B_IRET    = 7;
  localparam int B_JCC     = 8;
  localparam int B_JMP     = 9;
  localparam int B_IRQ     = 10;
  localparam int B_ICALL   = 11;
  localparam int B_ABORT   = 12;
  localparam int B_IN_TX   = 13;
  localparam int B_NO_TX   = 14;
  localparam int B_ZCALL   = 15;
  localparam int B_CSTACK  = 16;
  localparam int B_IJMP    = 17;

  localparam int CLASS_LO  = 2;

  typedef logic [TYPE_W-1:0] br_type_t;

  function automatic br_type_t bit_of(input int pos);
    br_type_t t;
    t      = '0;
    t[pos] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/br_cls_esc_decode.sv
module br_cls_esc_decode
  import br_cls_pkg::*;
(
  input  logic [OP_W-1:0] op1_i,
  output br_type_t        kind_o
);
  always_comb begin
    kind_o = '0;
    case (op1_i) inside
      8'h05, 8'h34:   kind_o = bit_of(B_SYSCALL);
      8'h07, 8'h35:   kind_o = bit_of(B_SYSRET);
      [8'h80:8'h8F]:  kind_o = bit_of(B_JCC);
      default:        kind_o = '0;
    endcase
  end
endmodule

// File: rtl/br_cls_op_decode.sv
module br_cls_op_decode
  import br_cls_pkg::*;
(
  input  logic [OP_W-1:0]  op0_i,
  input  logic [OP_W-1:0]  op1_i,
  input  logic             imm_zero_i,
  input  logic [REG_W-1:0] modrm_reg_i,
  output br_type_t         kind_o
);
  br_type_t esc_kind;

  br_cls_esc_decode u_esc (
    .op1_i  (op1_i),
    .kind_o (esc_kind)
  );

  always_comb begin
    kind_o = '0;
    case (op0_i) inside
      8'h0F:                       kind_o = esc_kind;
      [8'h70:8'h7F], [8'hE0:8'hE3]: kind_o = bit_of(B_JCC);
      8'hC2, 8'hC3, 8'hCA, 8'hCB:   kind_o = bit_of(B_RET);
      8'hCF:                       kind_o = bit_of(B_IRET);
      [8'hCC:8'hCE]:               kind_o = bit_of(B_INT);
      8'hE8:                       kind_o = imm_zero_i ? bit_of(B_ZCALL) : bit_of(B_CALL);
      8'h9A:                       kind_o = bit_of(B_CALL);
      [8'hE9:8'hEB]:               kind_o = bit_of(B_JMP);
      8'hFF: begin
        case (modrm_reg_i)
          3'd2, 3'd3: kind_o = bit_of(B_ICALL);
          3'd4, 3'd5: kind_o = bit_of(B_IJMP);
          default:    kind_o = '0;
        endcase
      end
      default:                     kind_o = '0;
    endcase
  end
endmodule

// File: rtl/br_cls_priv_fix.sv
module br_cls_priv_fix
  import br_cls_pkg::*;
(
  input  br_type_t kind_i,
  input  logic     op_ok_i,
  input  logic     abort_i,
  input  logic     src_zero_i,
  input  logic     dst_zero_i,
  input  logic     src_kern_i,
  input  logic     dst_kern_i,
  output br_type_t type_o
);
  br_type_t priv;
  br_type_t remap;
  logic     ring_up;

  assign priv    = dst_kern_i ? bit_of(B_KERN) : bit_of(B_USER);
  assign ring_up = !src_kern_i && dst_kern_i;

  // user->kernel entry not caused by syscall/int is an irq or fault
  always_comb begin
    remap = kind_i;
    if (ring_up && kind_i != bit_of(B_SYSCALL) && kind_i != bit_of(B_INT))
      remap = bit_of(B_IRQ);
  end

  always_comb begin
    if (src_zero_i || dst_zero_i)
      type_o = '0;
    else if (abort_i)
      type_o = bit_of(B_ABORT) | priv;
    else if (!op_ok_i)
      type_o = bit_of(B_ABORT);
    else if (remap != '0)
      type_o = remap | priv;
    else
      type_o = '0;
  end
endmodule

// File: rtl/br_type_classifier.sv
module br_type_classifier
  import br_cls_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   op0_i,
  input  logic [OP_W-1:0]   op1_i,
  input  logic              imm_zero_i,
  input  logic [REG_W-1:0]  modrm_reg_i,
  input  logic              op_ok_i,
  input  logic              abort_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  input  logic              src_kern_i,
  input  logic              dst_kern_i,
  output logic              out_valid_o,
  output logic [TYPE_W-1:0] type_o
);
  br_type_t kind;
  br_type_t result;

  br_cls_op_decode u_dec (
    .op0_i       (op0_i),
    .op1_i       (op1_i),
    .imm_zero_i  (imm_zero_i),
    .modrm_reg_i (modrm_reg_i),
    .kind_o      (kind)
  );

  br_cls_priv_fix u_fix (
    .kind_i     (kind),
    .op_ok_i    (op_ok_i),
    .abort_i    (abort_i),
    .src_zero_i (src_zero_i),
    .dst_zero_i (dst_zero_i),
    .src_kern_i (src_kern_i),
    .dst_kern_i (dst_kern_i),
    .type_o     (result)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic     vld_q;
      br_type_t type_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q  <= 1'b0;
          type_q <= '0;
        end else begin
          vld_q <= in_valid_i;
          if (in_valid_i) type_q <= result;
        end
      end

      assign out_valid_o = vld_q;
      assign type_o      = type_q;

      // R2
      valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
      // R2
      valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
      // R2
      type_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(type_o));
      // R3
      zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && (src_zero_i || dst_zero_i) |=> type_o == '0);
      // R4
      abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && !src_zero_i && !dst_zero_i && abort_i |=>
          type_o == (bit_of(B_ABORT) | ($past(dst_kern_i) ? bit_of(B_KERN) : bit_of(B_USER))));
      // R5
      no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && !src_zero_i && !dst_zero_i && !abort_i && !op_ok_i |=>
          type_o == bit_of(B_ABORT));
      // R11
      one_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $onehot0(type_o[TYPE_W-1:CLASS_LO]));
      // R11
      one_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> !(type_o[B_USER] && type_o[B_KERN]));
    end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign type_o      = result;
    end
  endgenerate
endmodule

// File: tb/br_type_classifier_bench.sv
module br_type_classifier_bench;
  localparam logic [17:0] T_U  = 18'h1;
  localparam logic [17:0] T_K  = 18'h2;
  localparam logic [17:0] T_CA = 18'h1 << 2;
  localparam logic [17:0] T_RT = 18'h1 << 3;
  localparam logic [17:0] T_SC = 18'h1 << 4;
  localparam logic [17:0] T_SR = 18'h1 << 5;
  localparam logic [17:0] T_IN = 18'h1 << 6;
  localparam logic [17:0] T_IR = 18'h1 << 7;
  localparam logic [17:0] T_CC = 18'h1 << 8;
  localparam logic [17:0] T_JM = 18'h1 << 9;
  localparam logic [17:0] T_IQ = 18'h1 << 10;
  localparam logic [17:0] T_IC = 18'h1 << 11;
  localparam logic [17:0] T_AB = 18'h1 << 12;
  localparam logic [17:0] T_ZC = 18'h1 << 15;
  localparam logic [17:0] T_IJ = 18'h1 << 17;

  typedef struct packed {
    logic [7:0]  op0;
    logic [7:0]  op1;
    logic        immz;
    logic [2:0]  mreg;
    logic        ok;
    logic        abt;
    logic        sz;
    logic        dz;
    logic        sk;
    logic        dk;
    logic [17:0] exp;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic [7:0] op0, logic [7:0] op1, logic immz, logic [2:0] mreg,
                              logic ok, logic abt, logic sz, logic dz, logic sk, logic dk,
                              logic [17:0] exp, logic [3:0] req);
    return '{op0, op1, immz, mreg, ok, abt, sz, dz, sk, dk, exp, req};
  endfunction

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    mk(8'h0F, 8'h05, 0, 0, 1, 0, 0, 0, 0, 1, T_SC | T_K, 6),  // R6 syscall, no remap
    mk(8'h0F, 8'h34, 0, 0, 1, 0, 0, 0, 0, 0, T_SC | T_U, 6),  // R6
    mk(8'h0F, 8'h07, 0, 0, 1, 0, 0, 0, 1, 0, T_SR | T_U, 6),  // R6
    mk(8'h0F, 8'h35, 0, 0, 1, 0, 0, 0, 1, 1, T_SR | T_K, 6),  // R6
    mk(8'h0F, 8'h8A, 0, 0, 1, 0, 0, 0, 0, 0, T_CC | T_U, 6),  // R6
    mk(8'h0F, 8'h10, 0, 0, 1, 0, 0, 0, 0, 0, 18'h0,      6),  // R6 unknown escape
    mk(8'h75, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, T_CC | T_U, 7),  // R7
    mk(8'hE2, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, T_CC | T_U, 7),  // R7
    mk(8'hC3, 8'h00, 0, 0, 1, 0, 0, 0, 1, 1, T_RT | T_K, 7),  // R7
    mk(8'hCA, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, T_RT | T_U, 7),  // R7
    mk(8'hCF, 8'h00, 0, 0, 1, 0, 0, 0, 1, 0, T_IR | T_U, 7),  // R7
    mk(8'hCD, 8'h00, 0, 0, 1, 0, 0, 0, 0, 1, T_IN | T_K, 7),  // R7 int, no remap
    mk(8'hCC, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, T_IN | T_U, 7),  // R7
    mk(8'hE8, 8'h00, 1, 0, 1, 0, 0, 0, 0, 0, T_ZC | T_U, 8),  // R8
    mk(8'hE8, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, T_CA | T_U, 8),  // R8
    mk(8'h9A, 8'h00, 1, 0, 1, 0, 0, 0, 0, 0, T_CA | T_U, 8),  // R8 imm flag ignored
    mk(8'hEA, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, T_JM | T_U, 8),  // R8
    mk(8'hFF, 8'h00, 0, 2, 1, 0, 0, 0, 0, 0, T_IC | T_U, 9),  // R9
    mk(8'hFF, 8'h00, 0, 5, 1, 0, 0, 0, 1, 1, T_IJ | T_K, 9),  // R9
    mk(8'hFF, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, 18'h0,      9),  // R9 other reg
    mk(8'hFF, 8'h00, 0, 7, 1, 0, 0, 0, 0, 1, T_IQ | T_K, 10), // R10 remap of no type
    mk(8'hC3, 8'h00, 0, 0, 1, 0, 0, 0, 0, 1, T_IQ | T_K, 10), // R10
    mk(8'h0F, 8'h80, 0, 0, 1, 0, 0, 0, 0, 1, T_IQ | T_K, 10), // R10
    mk(8'h90, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, 18'h0,      11), // R11 no type stays zero
    mk(8'hC3, 8'h00, 0, 0, 1, 1, 0, 0, 0, 1, T_AB | T_K, 4),  // R4
    mk(8'hC3, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, T_AB,       5),  // R5
    mk(8'hC3, 8'h00, 0, 0, 1, 1, 1, 0, 0, 0, 18'h0,      3),  // R3 src zero beats abort
    mk(8'hC3, 8'h00, 0, 0, 1, 0, 0, 1, 1, 1, 18'h0,      3),  // R3
    mk(8'hC3, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0, T_AB | T_U, 4),  // R4 abort beats no fetch
    mk(8'hCD, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, T_AB,       5)   // R5 no remap
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  op0_i = '0, op1_i = '0;
  logic        imm_zero_i = 1'b0;
  logic [2:0]  modrm_reg_i = '0;
  logic        op_ok_i = 1'b1, abort_i = 1'b0, src_zero_i = 1'b0, dst_zero_i = 1'b0;
  logic        src_kern_i = 1'b0, dst_kern_i = 1'b0;
  logic        out_valid_o;
  logic [17:0] type_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  br_type_classifier u_br_type_classifier (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .op0_i(op0_i), .op1_i(op1_i), .imm_zero_i(imm_zero_i), .modrm_reg_i(modrm_reg_i),
    .op_ok_i(op_ok_i), .abort_i(abort_i), .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i),
    .src_kern_i(src_kern_i), .dst_kern_i(dst_kern_i),
    .out_valid_o(out_valid_o), .type_o(type_o)
  );

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    op0_i = v.op0; op1_i = v.op1; imm_zero_i = v.immz; modrm_reg_i = v.mreg;
    op_ok_i = v.ok; abort_i = v.abt; src_zero_i = v.sz; dst_zero_i = v.dz;
    src_kern_i = v.sk; dst_kern_i = v.dk;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {17'h0, out_valid_o}, 18'h0);
    chk("R1 type in reset", type_o, 18'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {17'h0, out_valid_o}, 18'h0);
    chk("R1 type after reset", type_o, 18'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      in_valid_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0;
      chk($sformatf("R2 valid vec %0d", i), {17'h0, out_valid_o}, 18'h1);
      chk($sformatf("R%0d vec %0d", VEC[i].req, i), type_o, VEC[i].exp);
    end

    // R2 hold while idle: change inputs, output must not move
    @(negedge clk);
    drive(VEC[0]);
    in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    drive(VEC[17]);
    @(negedge clk);
    chk("R2 valid drops", {17'h0, out_valid_o}, 18'h0);
    chk("R2 type holds", type_o, T_SC | T_K);
    @(negedge clk);
    chk("R2 type still held", type_o, T_SC | T_K);

    // R2 back-to-back inputs
    drive(VEC[13]);
    in_valid_i = 1'b1;
    @(negedge clk);
    chk("R2 b2b first", type_o, T_ZC | T_U);
    drive(VEC[18]);
    @(negedge clk);
    in_valid_i = 1'b0;
    chk("R2 b2b second", type_o, T_IJ | T_K);
    chk("R2 b2b valid", {17'h0, out_valid_o}, 18'h1);

    // R1 reset clears held result
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reclear type", type_o, 18'h0);
    chk("R1 reclear valid", {17'h0, out_valid_o}, 18'h0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule